// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller

This block turns simple CPU-side read and write requests into the command sequence a row/column organised DRAM array expects. A flat supercell address is cut into a row index (upper bits) and a column index (lower bits). Both indices travel over one shared narrow address bus at different times, each qualified by its own strobe: the row strobe opens a row into the array's row buffer, and the column strobe then selects one supercell from that buffer for reading or writing.

The controller remembers which row is open. A request to the open row goes straight to the column phase. A request to another row first closes the open row, which writes the row buffer back to the array, and then opens the new one. A refresh timer issues one refresh command every `REF_INTERVAL` cycles, so every row is refreshed within `ROWS * REF_INTERVAL` cycles. The rows are taken in ascending order. A pending refresh blocks new requests, and any open row is closed before the refresh command is issued.

Top module: `dram_ctrl`

## Requirements
- R1: A request address is split into a row index (bits `[ROW_BITS+COL_BITS-1:COL_BITS]`) and a column index (bits `[COL_BITS-1:0]`). The row index is placed on `dram_addr_o` in the cycle `dram_ras_o` is high, and the column index in the cycle `dram_cas_o` is high.
- R2: A request accepted while no row is open produces a row strobe in the next cycle and a column strobe in the cycle after that. `rsp_valid_o` is high in the third cycle after acceptance, and for a read it carries the supercell value.
- R3: A request to the open row issues no row strobe. The column strobe follows in the cycle after acceptance, and `rsp_valid_o` comes in the second cycle.
- R4: A request to a row other than the open row issues a precharge strobe with the open row on `dram_addr_o`, then a row strobe with the new row, then a column strobe. `rsp_valid_o` comes in the fourth cycle after acceptance.
- R5: A write follows the same sequence with `dram_we_o` high during the column strobe and the data on `dram_wdata_o`. Its response returns the written value, and later reads of that address return it, including after the row has been closed.
- R6: A refresh command (`dram_ref_o` with a row index on `dram_addr_o`) is issued every `REF_INTERVAL` cycles, delayed only by the command in progress. Row indices go in ascending order and wrap, so no row goes longer than `ROWS * REF_INTERVAL` cycles plus a few cycles between refreshes.
- R7: While a refresh is pending, `req_ready_o` is low. A refresh is never issued while a row is open; the open row is precharged first. At most one of the four strobes is high in any cycle.
- R8: `rsp_valid_o` is high for exactly one cycle per accepted request, and `req_ready_o` is low from the cycle after acceptance until the response.
- R9: During and right after reset, no strobe is high, `rsp_valid_o` is low, `req_ready_o` is high, and no row is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ROW_BITS+COL_BITS | Flat supercell address |
| req_wdata_i | input | DATA_W | Write data |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | DATA_W | Read data, or written data for writes |
| dram_addr_o | output | max(ROW_BITS,COL_BITS) | Shared row/column/refresh index bus |
| dram_ras_o | output | 1 | Row strobe: open row into row buffer |
| dram_cas_o | output | 1 | Column strobe: access supercell in row buffer |
| dram_we_o | output | 1 | Write qualifier for the column strobe |
| dram_pre_o | output | 1 | Precharge: write row buffer back, close row |
| dram_ref_o | output | 1 | Refresh the row on the address bus |
| dram_wdata_o | output | DATA_W | Write data to the array |
| dram_rdata_i | input | DATA_W | Supercell value from the row buffer |

## Verification
The bench builds the controller with 4 rows, 4 columns and 8-bit supercells, matching a 16 x 8 array. It sets `REF_INTERVAL` to 24, which makes refreshes land in every phase of a request: during a column access, between precharge and row open, and right after an idle period with a row open. It also makes the refresh row counter wrap many times within a short run. Random traffic is biased towards the last row used, so page hits, misses and accesses from a closed row all occur often. The behavioural array in the bench writes back on precharge, so any lost write-back shows up in the read data.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_PRE,
    ST_REF
  } ctrl_state_e;
endpackage

// File: rtl/dram_addr_split.sv
module dram_addr_split #(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  localparam int ADDR_W  = ROW_BITS + COL_BITS
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [ROW_BITS-1:0] row_o,
  output logic [COL_BITS-1:0] col_o
);
  assign row_o = addr_i[ADDR_W-1:COL_BITS];
  assign col_o = addr_i[COL_BITS-1:0];
endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int ROW_BITS     = 2,
  parameter int REF_INTERVAL = 7800,
  localparam int CNT_W       = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ref_done_i,
  output logic                ref_pend_o,
  output logic [ROW_BITS-1:0] ref_row_o
);
  logic [CNT_W-1:0]    cnt_q;
  logic                tick;
  logic                pend_q;
  logic [ROW_BITS-1:0] row_q;

  assign tick = (cnt_q == CNT_W'(REF_INTERVAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      row_q  <= '0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick)            pend_q <= 1'b1;
      else if (ref_done_i) pend_q <= 1'b0;
      if (ref_done_i)      row_q  <= row_q + 1'b1;
    end
  end

  assign ref_pend_o = pend_q;
  assign ref_row_o  = row_q;

  // R6
  no_lost_refresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |-> (!pend_q || ref_done_i));
  // R6
  ref_row_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_done_i |=> (row_q == $past(row_q) + 1'b1));
endmodule

// File: rtl/dram_ctrl_fsm.sv
module dram_ctrl_fsm
  import dram_ctrl_pkg::*;
#(
  parameter int ROW_BITS = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [ROW_BITS-1:0] req_row_i,
  input  logic [ROW_BITS-1:0] lat_row_i,
  input  logic                ref_pend_i,
  output ctrl_state_e         state_o,
  output logic                req_ready_o,
  output logic                accept_o,
  output logic                ref_done_o,
  output logic [ROW_BITS-1:0] open_row_o
);
  ctrl_state_e         state_q, state_d;
  logic                req_pend_q;
  logic                row_open_q;
  logic [ROW_BITS-1:0] open_row_q;
  logic                hit;

  assign hit         = row_open_q && (req_row_i == open_row_q);
  assign req_ready_o = (state_q == ST_IDLE) && !ref_pend_i;
  assign accept_o    = req_ready_o && req_valid_i;
  assign ref_done_o  = (state_q == ST_REF);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_pend_i)       state_d = row_open_q ? ST_PRE : ST_REF;
        else if (req_valid_i) state_d = hit ? ST_COL : (row_open_q ? ST_PRE : ST_ROW);
      end
      ST_PRE: begin
        if (ref_pend_i)      state_d = ST_REF;
        else if (req_pend_q) state_d = ST_ROW;
        else                 state_d = ST_IDLE;
      end
      ST_ROW:  state_d = ST_COL;
      ST_COL:  state_d = ST_IDLE;
      ST_REF:  state_d = req_pend_q ? ST_ROW : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      req_pend_q <= 1'b0;
      row_open_q <= 1'b0;
      open_row_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept_o)               req_pend_q <= 1'b1;
      else if (state_q == ST_COL) req_pend_q <= 1'b0;
      if (state_q == ST_ROW) begin
        row_open_q <= 1'b1;
        open_row_q <= lat_row_i;
      end else if (state_q == ST_PRE) begin
        row_open_q <= 1'b0;
      end
    end
  end

  assign state_o    = state_q;
  assign open_row_o = open_row_q;

  // R7
  ref_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REF) |-> !row_open_q);
  // R3
  col_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COL) |-> row_open_q);
  // R4
  row_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ROW) |-> !row_open_q);
  // R3
  hit_fast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && hit) |=> (state_q == ST_COL));
  // R8
  ready_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !req_ready_o);
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl
  import dram_ctrl_pkg::*;
#(
  parameter int ROW_BITS     = 2,
  parameter int COL_BITS     = 2,
  parameter int DATA_W       = 8,
  parameter int REF_INTERVAL = 7800,
  localparam int ADDR_W      = ROW_BITS + COL_BITS,
  localparam int BUS_W       = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [BUS_W-1:0]  dram_addr_o,
  output logic              dram_ras_o,
  output logic              dram_cas_o,
  output logic              dram_we_o,
  output logic              dram_pre_o,
  output logic              dram_ref_o,
  output logic [DATA_W-1:0] dram_wdata_o,
  input  logic [DATA_W-1:0] dram_rdata_i
);
  ctrl_state_e         state;
  logic                accept;
  logic                ref_pend;
  logic                ref_done;
  logic [ROW_BITS-1:0] ref_row;
  logic [ROW_BITS-1:0] open_row;
  logic [ROW_BITS-1:0] in_row, lat_row;
  logic [COL_BITS-1:0] in_col, lat_col;
  logic [ADDR_W-1:0]   lat_addr_q;
  logic                lat_we_q;
  logic [DATA_W-1:0]   lat_wdata_q;
  logic                rsp_valid_q;
  logic [DATA_W-1:0]   rsp_rdata_q;

  dram_addr_split #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_split_in (
    .addr_i(req_addr_i), .row_o(in_row), .col_o(in_col));

  dram_addr_split #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_split_lat (
    .addr_i(lat_addr_q), .row_o(lat_row), .col_o(lat_col));

  dram_refresh_timer #(.ROW_BITS(ROW_BITS), .REF_INTERVAL(REF_INTERVAL)) u_ref (
    .clk_i, .rst_ni, .ref_done_i(ref_done), .ref_pend_o(ref_pend), .ref_row_o(ref_row));

  dram_ctrl_fsm #(.ROW_BITS(ROW_BITS)) u_fsm (
    .clk_i, .rst_ni,
    .req_valid_i, .req_row_i(in_row), .lat_row_i(lat_row),
    .ref_pend_i(ref_pend),
    .state_o(state), .req_ready_o, .accept_o(accept),
    .ref_done_o(ref_done), .open_row_o(open_row));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_addr_q  <= '0;
      lat_we_q    <= 1'b0;
      lat_wdata_q <= '0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      if (accept) begin
        lat_addr_q  <= req_addr_i;
        lat_we_q    <= req_we_i;
        lat_wdata_q <= req_wdata_i;
      end
      rsp_valid_q <= (state == ST_COL);
      if (state == ST_COL) rsp_rdata_q <= lat_we_q ? lat_wdata_q : dram_rdata_i;
    end
  end

  // shared index bus: content depends on the command phase
  always_comb begin
    unique case (state)
      ST_ROW:  dram_addr_o = BUS_W'(lat_row);
      ST_COL:  dram_addr_o = BUS_W'(lat_col);
      ST_PRE:  dram_addr_o = BUS_W'(open_row);
      ST_REF:  dram_addr_o = BUS_W'(ref_row);
      default: dram_addr_o = '0;
    endcase
  end

  assign dram_ras_o   = (state == ST_ROW);
  assign dram_cas_o   = (state == ST_COL);
  assign dram_pre_o   = (state == ST_PRE);
  assign dram_ref_o   = (state == ST_REF);
  assign dram_we_o    = dram_cas_o && lat_we_q;
  assign dram_wdata_o = lat_wdata_q;
  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_rdata_o  = rsp_rdata_q;

  // R7
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dram_ras_o, dram_cas_o, dram_pre_o, dram_ref_o}));
  // R8
  rsp_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  // R2
  cas_after_ras_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dram_ras_o |=> dram_cas_o);
  // R5
  we_only_cas_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dram_we_o |-> dram_cas_o);
endmodule

// File: tb/sim_dram_ctrl.sv
module sim_dram_ctrl;
  localparam int PERIOD   = 10;
  localparam int RB       = 2;
  localparam int CB       = 2;
  localparam int DW       = 8;
  localparam int REF_INT  = 24;
  localparam int ROWS     = 1 << RB;
  localparam int COLS     = 1 << CB;
  localparam int NCELL    = ROWS * COLS;
  localparam int BUS_W    = (RB > CB) ? RB : CB;
  localparam int AGE_MAX  = ROWS * REF_INT + 8;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0;
  logic [RB+CB-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [BUS_W-1:0] dram_addr;
  logic ras, cas, dwe, pre, refr;
  logic [DW-1:0] dram_wdata, dram_rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  dram_ctrl #(.ROW_BITS(RB), .COL_BITS(CB), .DATA_W(DW), .REF_INTERVAL(REF_INT)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_ready_o(req_ready), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .dram_addr_o(dram_addr), .dram_ras_o(ras), .dram_cas_o(cas), .dram_we_o(dwe),
    .dram_pre_o(pre), .dram_ref_o(refr), .dram_wdata_o(dram_wdata), .dram_rdata_i(dram_rdata));

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural array with row buffer, evaluated away from the active edge
  logic [DW-1:0] mem [ROWS][COLS];
  logic [DW-1:0] rowbuf [COLS];
  logic [DW-1:0] gold [NCELL];
  bit m_open = 0;
  int m_row = 0;
  int age [ROWS];
  int exp_ref = 0;
  int ref_seen = 0;

  assign dram_rdata = rowbuf[dram_addr[CB-1:0]];

  initial begin
    for (int r = 0; r < ROWS; r++) begin
      age[r] = 0;
      for (int c = 0; c < COLS; c++) mem[r][c] = '0;
    end
    for (int c = 0; c < COLS; c++) rowbuf[c] = '0;
    for (int i = 0; i < NCELL; i++) gold[i] = '0;
  end

  always @(negedge clk) if (rst_n) begin
    for (int r = 0; r < ROWS; r++) age[r]++;
    if (ras) begin
      check(!m_open, "R4", "row strobe while row open", 1, 0);
      for (int c = 0; c < COLS; c++) rowbuf[c] = mem[dram_addr][c];
      m_open = 1;
      m_row  = int'(dram_addr);
    end
    if (cas) begin
      check(m_open, "R2", "column strobe with no open row", 0, 1);
      if (dwe) rowbuf[dram_addr[CB-1:0]] = dram_wdata;
    end
    if (pre) begin
      check(m_open && int'(dram_addr) == m_row, "R4", "precharge row index", int'(dram_addr), m_row);
      for (int c = 0; c < COLS; c++) mem[m_row][c] = rowbuf[c];
      m_open = 0;
    end
    if (refr) begin
      check(!m_open, "R7", "refresh while row open", 1, 0);
      check(int'(dram_addr) == exp_ref, "R6", "refresh row order", int'(dram_addr), exp_ref);
      check(age[dram_addr] <= AGE_MAX, "R6", "row refresh age", age[dram_addr], AGE_MAX);
      age[dram_addr] = 0;
      exp_ref = (exp_ref + 1) % ROWS;
      ref_seen++;
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic do_req(bit we, int addr, logic [DW-1:0] wd);
    int row, lat, exp_lat, rsn;
    bit eo;
    int er;
    logic [DW-1:0] exp_d;
    string tag;
    row = addr >> CB;
    req_valid = 1;
    req_we    = we;
    req_addr  = (RB+CB)'(addr);
    req_wdata = wd;
    while (!req_ready) tick();
    eo  = m_open;
    er  = m_row;
    rsn = ref_seen;
    tick();
    req_valid = 0;
    lat = 1;
    while (!rsp_valid && lat < 20) begin
      tick();
      lat++;
    end
    exp_lat = !eo ? 3 : (er == row ? 2 : 4);
    tag = !eo ? "R2" : (er == row ? "R3" : "R4");
    if (ref_seen == rsn) check(lat == exp_lat, tag, "response latency", lat, exp_lat);
    exp_d = we ? wd : gold[addr];
    check(rsp_rdata == exp_d, we ? "R5" : "R2", "response data", int'(rsp_rdata), int'(exp_d));
    check(m_open && m_row == row, "R1", "row index driven on strobe", m_row, row);
    if (we) gold[addr] = wd;
    tick();
    check(!rsp_valid, "R8", "response pulse width", int'(rsp_valid), 0);
  endtask

  initial begin
    int r, a, last;
    r = int'($urandom(32'd4242));
    tick();
    // R9 reset state
    check(req_ready && !rsp_valid, "R9", "ready/rsp in reset", int'({req_ready, rsp_valid}), 2);
    check({ras, cas, pre, refr} == 4'b0, "R9", "strobes in reset", int'({ras, cas, pre, refr}), 0);
    rst_n = 1;
    tick();
    check({ras, cas, pre, refr} == 4'b0 && !rsp_valid, "R9", "idle after reset", int'({ras, cas, pre, refr, rsp_valid}), 0);
    // R2/R5 first access from closed row, then fill array
    for (int i = 0; i < NCELL; i++) do_req(1, i, DW'(8'h30 + i * 7));
    // R3 same-row reads, R4 row changes
    for (int i = 0; i < NCELL; i++) do_req(0, i, '0);
    for (int i = 0; i < NCELL; i++) do_req(0, (i % ROWS) * COLS + (i / ROWS), '0);
    // R7 idle with a row open: precharge must precede refresh
    do_req(0, 5, '0);
    repeat (3 * ROWS * REF_INT) tick();
    // R5 write-back after close
    do_req(1, 2, 8'hA5);
    do_req(0, 14, '0);
    do_req(0, 2, '0);
    // random traffic biased to last row
    last = 0;
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(0, 1) == 1) a = (last & ~(COLS - 1)) | int'($urandom_range(0, COLS - 1));
      else a = int'($urandom_range(0, NCELL - 1));
      do_req(bit'($urandom_range(0, 1)), a, DW'($urandom()));
      last = a;
      if ($urandom_range(0, 7) == 0) repeat ($urandom_range(1, 30)) tick();
    end
    // R6 final age bound
    for (int k = 0; k < ROWS; k++) check(age[k] <= AGE_MAX, "R6", "final row age", age[k], AGE_MAX);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule